// File: doc/BRIEF.md
# GPIO input capture and interrupt unit

This block takes a bank of general-purpose input pins, registers them, and turns selected transitions or levels into one level-sensitive interrupt line for a host processor. Each pin is captured either on the system clock or on an external reference clock. For the external clock, software picks whether the rising or the falling edge is used, and the captured value is then brought into the system clock domain through a synchronizer. The block has a small register file that an upstream bus front end drives with plain write and read strobes.

Per pin, software chooses a trigger kind: single edge, level, or any change. It also sets a polarity bit and an enable bit. A qualifying event on an enabled pin sets that pin's sticky status bit and a global pending flag. The interrupt line is the global pending flag gated by a global enable. Software clears the interrupt by writing zeros to the status bits and to the pending flag, or masks it by clearing the global enable. Reset leaves every source masked.

Register map (3-bit address, data zero-extended): 0 live input view (read-only), 1 pin enables, 2 polarity, 3 external-clock select, 4 external falling-edge select, 5 sticky status, 6 trigger kinds (2 bits per pin, pin i at bits 2i+1:2i), 7 control (bit 0 global enable, bit 1 global pending flag).

Top module: `gpio_irq_unit`

## Requirements
- R1: A synchronous active-high reset clears all registers, the pending flag, the global enable and the interrupt output to 0.
- R2: For a pin with external-clock select 0, address 0 shows the pin value captured at the previous system clock edge. rd_data is registered and carries the word addressed by rd_addr at the preceding rising edge.
- R3: For a pin with external-clock select 1, the pin is captured on ext_clk rising (register 4 bit = 0) or falling (bit = 1). The captured value reaches address 0 two system clock edges later.
- R4: Trigger kind 00 (edge): polarity 1 marks a 0-to-1 change of the pin's input view as an event, and polarity 0 marks a 1-to-0 change. With the system-clock path, the status bit is set at the second clock edge after the pin changes.
- R5: Trigger kind 01 (level): an event occurs on every cycle where the input view equals the polarity bit, so the status bit cannot be cleared while that level holds.
- R6: Trigger kinds 10 and 11 (change): every transition of the input view is an event, whatever the polarity.
- R7: An event on a pin whose enable bit is 0 sets neither its status bit nor the pending flag.
- R8: Status bits are sticky. Writing address 5 clears the bits written as 0 and leaves the bits written as 1 unchanged.
- R9: A pin event in the same cycle as a status write that clears its bit leaves the bit set.
- R10: The pending flag (control bit 1) sets whenever any enabled pin has an event, and a control write with bit 1 = 0 clears it. The interrupt output equals pending flag AND global enable (control bit 0), one edge after either changes.
- R11: Writes to address 0 have no effect.
- R12: Configuration registers 1, 2, 3, 4 and 6 take a written value at the write edge and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External reference clock for input capture |
| pin_in | input | N_PINS | General-purpose input pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt output |

## Verification
On the system-clock path, a pin change appears in the input view one edge later and in status and irq two edges later. On the external path, a pin captured by an ext_clk edge appears in the input view two system edges later and in status and irq three edges later. Register writes take effect at their edge, and read data follows its address by one edge. The bench drives every input on falling clock edges and runs a behavioural model with these same latencies on each rising edge. It compares irq and rd_data against that model on every falling edge, and its directed reads wait out these delays before they compare against hand-computed words.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_VIEW = 3'd0;
  localparam logic [REG_AW-1:0] A_EN   = 3'd1;
  localparam logic [REG_AW-1:0] A_POL  = 3'd2;
  localparam logic [REG_AW-1:0] A_XSEL = 3'd3;
  localparam logic [REG_AW-1:0] A_XNEG = 3'd4;
  localparam logic [REG_AW-1:0] A_STAT = 3'd5;
  localparam logic [REG_AW-1:0] A_MODE = 3'd6;
  localparam logic [REG_AW-1:0] A_CTRL = 3'd7;

  localparam int CTRL_GEN  = 0;
  localparam int CTRL_FLAG = 1;

  typedef enum logic [1:0] {
    TRIG_EDGE   = 2'b00,
    TRIG_LEVEL  = 2'b01,
    TRIG_CHANGE = 2'b10,
    TRIG_CHG_B  = 2'b11
  } trig_kind_e;
endpackage

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] xsel,
  input  logic [N_PINS-1:0] xneg,
  output logic [N_PINS-1:0] view
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [N_PINS-1:0] cap_sys;
  logic [N_PINS-1:0] ext_rise_q;
  logic [N_PINS-1:0] ext_fall_q;
  logic [N_PINS-1:0] ext_pick;
  logic [N_PINS-1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) cap_sys <= '0;
    else     cap_sys <= pin_in;
  end

  always_ff @(posedge ext_clk) ext_rise_q <= pin_in;
  always_ff @(negedge ext_clk) ext_fall_q <= pin_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= ext_pick;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign ext_pick[g] = xneg[g] ? ext_fall_q[g] : ext_rise_q[g];
    assign view[g]     = xsel[g] ? sync_q[LAST][g] : cap_sys[g];
  end

  // R2: system-clock pins show the value present at the previous edge
  assert_sys_view_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((view ^ $past(pin_in)) & ~xsel) == '0));
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PINS-1:0]   view,
  input  logic [N_PINS-1:0]   pol,
  input  logic [2*N_PINS-1:0] kind,
  output logic [N_PINS-1:0]   evt
);
  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= view;
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    trig_kind_e k;
    assign k = trig_kind_e'(kind[2*g +: 2]);
    always_comb begin
      unique case (k)
        TRIG_EDGE:  evt[g] = pol[g] ? (view[g] & ~prev_q[g]) : (~view[g] & prev_q[g]);
        TRIG_LEVEL: evt[g] = (view[g] == pol[g]);
        default:    evt[g] = view[g] ^ prev_q[g];
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int KW = 2 * N_PINS;

  logic [N_PINS-1:0] en_q, pol_q, xsel_q, xneg_q, status_q;
  logic [KW-1:0]     kind_q;
  logic              gflag_q, gen_q, irq_q;
  logic [DATA_W-1:0] rd_q, rd_word;

  logic [N_PINS-1:0] view, evt, hit, status_nx;
  logic              wr_stat, wr_ctrl, gflag_nx, gen_nx;

  gpio_in_sample #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sample (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .pin_in(pin_in),
    .xsel(xsel_q), .xneg(xneg_q), .view(view)
  );

  gpio_trig_detect #(.N_PINS(N_PINS)) u_detect (
    .clk(clk), .rst(rst), .view(view), .pol(pol_q), .kind(kind_q), .evt(evt)
  );

  always_comb begin
    hit       = evt & en_q;
    wr_stat   = wr_en && (wr_addr == A_STAT);
    wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    status_nx = (wr_stat ? (status_q & wr_data[N_PINS-1:0]) : status_q) | hit;
    gflag_nx  = (wr_ctrl ? (gflag_q & wr_data[CTRL_FLAG]) : gflag_q) | (|hit);
    gen_nx    = wr_ctrl ? wr_data[CTRL_GEN] : gen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      gflag_q  <= 1'b0;
      gen_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nx;
      gflag_q  <= gflag_nx;
      gen_q    <= gen_nx;
      irq_q    <= gflag_nx & gen_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      xsel_q <= '0;
      xneg_q <= '0;
      kind_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_EN:    en_q   <= wr_data[N_PINS-1:0];
        A_POL:   pol_q  <= wr_data[N_PINS-1:0];
        A_XSEL:  xsel_q <= wr_data[N_PINS-1:0];
        A_XNEG:  xneg_q <= wr_data[N_PINS-1:0];
        A_MODE:  kind_q <= wr_data[KW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_VIEW:  rd_word = DATA_W'(view);
      A_EN:    rd_word = DATA_W'(en_q);
      A_POL:   rd_word = DATA_W'(pol_q);
      A_XSEL:  rd_word = DATA_W'(xsel_q);
      A_XNEG:  rd_word = DATA_W'(xneg_q);
      A_STAT:  rd_word = DATA_W'(status_q);
      A_MODE:  rd_word = DATA_W'(kind_q);
      default: rd_word = DATA_W'({gflag_q, gen_q});
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_word;
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  // R7: a pin with its enable low never gains a status bit
  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

  // R8: without a status write no status bit falls
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == A_STAT)) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9: an event always lands in status, even against a clearing write
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

  // R10: any enabled event raises the pending flag
  assert_flag_on_hit_R10: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> gflag_q);

  // R10: the interrupt needs both the pending flag and the global enable
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (gflag_q && gen_q));
endmodule

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;
  localparam int N = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1, ext_clk = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic irq;

  int n_checks = 0, n_fail = 0;
  logic [DW-1:0] r;

  always #2 clk = ~clk;

  gpio_irq_unit #(.N_PINS(N), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .pin_in(pin_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference model
  logic [N-1:0] m_pos = '0, m_neg = '0, m_cap, m_s1, m_s2, m_prev;
  logic [N-1:0] m_en, m_pol, m_xs, m_xn, m_st;
  logic [2*N-1:0] m_kind;
  logic m_gf, m_ge, m_irq;
  logic [DW-1:0] m_rd;

  always @(posedge ext_clk) m_pos = pin_in;
  always @(negedge ext_clk) m_neg = pin_in;

  always @(posedge clk) begin
    logic [N-1:0] v, ev, h, pick;
    if (rst) begin
      m_cap = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_en = '0; m_pol = '0; m_xs = '0; m_xn = '0; m_st = '0; m_kind = '0;
      m_gf = 0; m_ge = 0; m_irq = 0; m_rd = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        v[i] = m_xs[i] ? m_s2[i] : m_cap[i];
        pick[i] = m_xn[i] ? m_neg[i] : m_pos[i];
      end
      for (int i = 0; i < N; i++) begin
        case (m_kind[2*i +: 2])
          2'd0: ev[i] = m_pol[i] ? (v[i] && !m_prev[i]) : (!v[i] && m_prev[i]);
          2'd1: ev[i] = (v[i] == m_pol[i]);
          default: ev[i] = (v[i] != m_prev[i]);
        endcase
      end
      h = ev & m_en;
      case (rd_addr)
        3'd0: m_rd = DW'(v);
        3'd1: m_rd = DW'(m_en);
        3'd2: m_rd = DW'(m_pol);
        3'd3: m_rd = DW'(m_xs);
        3'd4: m_rd = DW'(m_xn);
        3'd5: m_rd = DW'(m_st);
        3'd6: m_rd = DW'(m_kind);
        default: m_rd = DW'({m_gf, m_ge});
      endcase
      if (wr_en && wr_addr == 3'd5) m_st = m_st & wr_data[N-1:0];
      m_st = m_st | h;
      if (wr_en && wr_addr == 3'd7) begin
        m_gf = m_gf & wr_data[1];
        m_ge = wr_data[0];
      end
      if (h != 0) m_gf = 1'b1;
      m_irq = m_gf & m_ge;
      if (wr_en) begin
        case (wr_addr)
          3'd1: m_en = wr_data[N-1:0];
          3'd2: m_pol = wr_data[N-1:0];
          3'd3: m_xs = wr_data[N-1:0];
          3'd4: m_xn = wr_data[N-1:0];
          3'd6: m_kind = wr_data[2*N-1:0];
          default: ;
        endcase
      end
      m_prev = v;
      m_s2 = m_s1;
      m_s1 = pick;
      m_cap = pin_in;
    end
  end

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd5: return "R8";
      3'd7: return "R10";
      default: return "R12";
    endcase
  endfunction

  logic [2:0] last_rd_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      n_checks++;
      if (irq !== m_irq) begin
        n_fail++;
        $display("FAIL R10 irq model compare: actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
      n_checks++;
      if (rd_data !== m_rd) begin
        n_fail++;
        $display("FAIL %s rd_data model compare: actual %h expected %h at %0t",
                 req_of(last_rd_addr), rd_data, m_rd, $time);
      end
    end
    last_rd_addr = rd_addr;
  end

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic setpin(input int i, input logic v);
    @(negedge clk); pin_in[i] = v;
  endtask

  task automatic ext_edge(input logic lvl);
    @(negedge clk); #1 ext_clk = lvl;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    ext_edge(1'b1); ext_edge(1'b0);
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1", "irq after reset", DW'(irq), 16'h0);
    rd(3'd5, r); check("R1", "status after reset", r, 16'h0);
    rd(3'd7, r); check("R1", "control after reset", r, 16'h0);
    rd(3'd1, r); check("R1", "enables after reset", r, 16'h0);

    wr(3'd1, 16'h00FF); wr(3'd2, 16'h000F); wr(3'd7, 16'h0001);
    // R4 rising on a falling-polarity pin: nothing
    setpin(4, 1'b1); idle(3);
    rd(3'd5, r); check("R4", "rise on falling-polarity pin", r, 16'h0);
    // R4 rising edge
    setpin(0, 1'b1); idle(2);
    check("R4", "irq after rising edge", DW'(irq), 16'h1);
    rd(3'd5, r); check("R4", "status after rise", r, 16'h01);
    setpin(4, 1'b0); idle(2);
    rd(3'd5, r); check("R4", "status after fall", r, 16'h11);
    // R8 partial clear
    wr(3'd5, 16'h0010); rd(3'd5, r); check("R8", "write-one keeps", r, 16'h10);
    check("R10", "irq held by flag", DW'(irq), 16'h1);
    wr(3'd5, 16'h0000); wr(3'd7, 16'h0001);
    rd(3'd5, r); check("R8", "status cleared", r, 16'h0);
    check("R10", "irq after flag clear", DW'(irq), 16'h0);
    // R7 masked pin
    wr(3'd1, 16'h00FE);
    setpin(0, 1'b0); idle(2); setpin(0, 1'b1); idle(3);
    rd(3'd5, r); check("R7", "masked pin status", r, 16'h0);
    check("R7", "masked pin irq", DW'(irq), 16'h0);
    wr(3'd1, 16'h00FF);
    // R5 level mode on pin 1
    wr(3'd6, 16'h0004);
    setpin(1, 1'b1); idle(3);
    wr(3'd5, 16'h0000); rd(3'd5, r); check("R5", "level holds status", r, 16'h02);
    setpin(1, 1'b0); idle(3);
    wr(3'd5, 16'h0000); wr(3'd7, 16'h0001);
    rd(3'd5, r); check("R5", "level released", r, 16'h0);
    // R6 change mode on pin 2
    wr(3'd6, 16'h0024);
    setpin(2, 1'b1); idle(3);
    rd(3'd5, r); check("R6", "change on rise", r, 16'h04);
    wr(3'd5, 16'h0000);
    setpin(2, 1'b0); idle(3);
    rd(3'd5, r); check("R6", "change on fall", r, 16'h04);
    wr(3'd5, 16'h0000); wr(3'd7, 16'h0001);
    // R9 event versus same-cycle clear on pin 3
    setpin(3, 1'b1);
    wr(3'd5, 16'h0000);
    rd(3'd5, r); check("R9", "event beats clear", r, 16'h08);
    // R10 global enable gating
    wr(3'd7, 16'h0002); idle(1);
    check("R10", "irq with global enable off", DW'(irq), 16'h0);
    rd(3'd7, r); check("R10", "flag kept while masked", r, 16'h2);
    wr(3'd7, 16'h0003); idle(1);
    check("R10", "irq with global enable on", DW'(irq), 16'h1);
    wr(3'd5, 16'h0000); wr(3'd7, 16'h0001); idle(1);
    check("R10", "irq after full clear", DW'(irq), 16'h0);
    // R11 and R2
    wr(3'd0, 16'hFFFF);
    rd(3'd0, r); check("R11", "view unchanged by write", r, 16'h09);
    check("R2", "view shows system-sampled pins", r, 16'h09);
    // R12 readback
    rd(3'd2, r); check("R12", "polarity readback", r, 16'h0F);
    rd(3'd6, r); check("R12", "trigger kind readback", r, 16'h24);
    // R3 external clock capture
    wr(3'd2, 16'h006F); wr(3'd4, 16'h0040); wr(3'd3, 16'h0060);
    setpin(5, 1'b1); setpin(6, 1'b1); idle(4);
    rd(3'd0, r); check("R3", "no ext edge yet", r, 16'h09);
    ext_edge(1'b1); idle(4);
    rd(3'd0, r); check("R3", "rising ext capture", r, 16'h29);
    rd(3'd5, r); check("R3", "status from ext rise", r, 16'h20);
    ext_edge(1'b0); idle(4);
    rd(3'd0, r); check("R3", "falling ext capture", r, 16'h69);
    rd(3'd5, r); check("R3", "status from ext fall", r, 16'h60);
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule